// File: doc/BRIEF.md
# HF Power Stage Fault Protection Supervisor

This block sits between the fault-sensing logic of an HF power stage and its gate driver. It takes digital over-current and over-voltage comparator flags, together with a periodically sampled load-mismatch proxy, and produces a single gate-enable output. It also produces a power-derate request, a stop indication, a lockout indication and a code naming the protection layer that tripped.

The work is split by time scale. The fast layer turns the gate off in the same cycle that a comparator flag rises. It then manages recovery. An over-current trip recovers by itself a bounded number of times, and each retry waits a minimum interval. An over-voltage trip needs either a manual reset or a timed safe window, chosen by a mode bit. The supervisory layer looks only at valid mismatch samples. Its first response to an excess is a derate request. It asks for a stop only when the excess persists, and it releases only after a run of consecutive in-range samples. All timers count sample ticks.

Top module: `hfs_top`

## Requirements
- R1: While `oc_flag_i` is high, `gate_en_o` is low in the same cycle, without waiting for any clock edge or tick.
- R2: After an over-current trip, `gate_en_o` returns high by itself only once the flag has cleared and at least `retry_gap_i` ticks have been counted since the trip.
- R3: When `retry_max_i` automatic recoveries have already been used, the next over-current trip sets `lockout_o`. While `lockout_o` is high, `gate_en_o` is low.
- R4: The retry count returns to zero after `retry_clear_i` fault-free ticks with the gate released, so trips spaced further apart than that never lead to lockout.
- R5: An over-voltage flag forces `gate_en_o` low in the same cycle. With `ov_timed_i` = 0, the gate comes back only on a `man_reset_i` pulse given after the flag has cleared. A pulse given while the flag is high is ignored.
- R6: With `ov_timed_i` = 1, the gate comes back after `ov_window_i` ticks with the over-voltage flag clear. No restart happens while `tick_i` stays low.
- R7: A valid sample with `mm_sample_i` > `mm_limit_i` sets `derate_o`. When `mm_persist_i` consecutive valid samples exceed the limit, `stop_o` rises and `gate_en_o` goes low. An in-range sample restarts this count.
- R8: Once raised, `derate_o` and `stop_o` clear together after `mm_release_i` consecutive in-range valid samples. An over-limit sample restarts the release count.
- R9: While a fast-layer fault holds the gate off (flag, retry wait, over-voltage hold or lockout), `derate_o` is forced low.
- R10: `fault_layer_o` reads 0 when no fault is recorded, 1 for an over-current trip, 2 for an over-voltage trip and 3 for a mismatch stop. A mismatch stop does not overwrite a fast-layer code. The code is kept until a `man_reset_i` pulse arrives with no flag active.
- R11: `lockout_o` clears only on `man_reset_i`, and only when no comparator flag is active.
- R12: After reset, `gate_en_o` = 1 and `derate_o`, `stop_o`, `lockout_o` and `fault_layer_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_flag_i | input | 1 | Over-current comparator flag (asynchronous) |
| ov_flag_i | input | 1 | Over-voltage comparator flag (asynchronous) |
| tick_i | input | 1 | Time base for all timers |
| mm_sample_i | input | DATA_W | Mismatch proxy sample |
| mm_valid_i | input | 1 | Strobe: `mm_sample_i` holds a new sample |
| mm_limit_i | input | DATA_W | Mismatch limit |
| mm_persist_i | input | CNT_W | Consecutive over-limit samples before stop |
| mm_release_i | input | CNT_W | Consecutive in-range samples before release |
| retry_max_i | input | RETRY_W | Allowed automatic over-current recoveries |
| retry_gap_i | input | TIMER_W | Minimum ticks between trip and retry |
| retry_clear_i | input | TIMER_W | Fault-free ticks that reset the retry count |
| ov_timed_i | input | 1 | Over-voltage restart: 0 manual, 1 timed |
| ov_window_i | input | TIMER_W | Safe-window ticks for timed restart |
| man_reset_i | input | 1 | Manual reset pulse |
| gate_en_o | output | 1 | Gate driver enable |
| derate_o | output | 1 | Power derate request |
| stop_o | output | 1 | Supervisory stop |
| lockout_o | output | 1 | Over-current retry lockout |
| fault_layer_o | output | 2 | Recorded fault layer code |

## Verification
The assertions assume that the programmed limits, counts and the retry maximum stay constant while the block runs. They also assume that a comparator flag stays high for at least three clock cycles, so the synchronizer always sees it. The bench changes settings only while the block is idle with no fault held, and it drives every flag pulse for three or more cycles. Mismatch samples are random values spread around the limit, with random gaps between valid strobes, so that persistence and release runs are both broken and completed.

// File: rtl/hfs_pkg.sv
`timescale 1ns/1ps
package hfs_pkg;

  typedef enum logic [1:0] {
    LAYER_NONE = 2'd0,
    LAYER_OC   = 2'd1,
    LAYER_OV   = 2'd2,
    LAYER_SUP  = 2'd3
  } layer_e;

  // counter already at or beyond a limit
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // one more event brings the counter to the limit
  function automatic logic next_hits(input logic [31:0] cnt, input logic [31:0] lim);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, lim};
  endfunction

endpackage

// File: rtl/hfs_sync.sv
`timescale 1ns/1ps
module hfs_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/hfs_oc_retry.sv
`timescale 1ns/1ps
module hfs_oc_retry
  import hfs_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               oc_s_i,
  input  logic               quiet_i,
  input  logic               man_reset_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  input  logic [TIMER_W-1:0] retry_gap_i,
  input  logic [TIMER_W-1:0] retry_clear_i,
  output logic               hold_o,
  output logic               lock_o,
  output logic               trip_evt_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  logic [TIMER_W-1:0] gap_q, run_q;
  logic [RETRY_W-1:0] retry_q;
  logic               hold_q, lock_q;
  logic               release_ok, lock_clear;

  assign trip_evt_o = oc_s_i && !hold_q && !lock_q;
  assign release_ok = hold_q && !oc_s_i && at_limit(32'(gap_q), 32'(retry_gap_i));
  assign lock_clear = lock_q && man_reset_i && quiet_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      lock_q  <= 1'b0;
      retry_q <= '0;
      gap_q   <= '0;
      run_q   <= '0;
    end else if (lock_clear) begin
      hold_q  <= 1'b0;
      lock_q  <= 1'b0;
      retry_q <= '0;
      gap_q   <= '0;
      run_q   <= '0;
    end else if (trip_evt_o) begin
      hold_q <= 1'b1;
      gap_q  <= '0;
      run_q  <= '0;
      if (at_limit(32'(retry_q), 32'(retry_max_i))) lock_q <= 1'b1;
      else                                           retry_q <= retry_q + RETRY_W'(1);
    end else if (hold_q) begin
      if (!lock_q) begin
        if (release_ok)                  hold_q <= 1'b0;
        else if (tick_i && !(&gap_q))    gap_q  <= gap_q + TIMER_W'(1);
      end
    end else if (!oc_s_i && retry_q != '0 && tick_i) begin
      if (next_hits(32'(run_q), 32'(retry_clear_i))) begin
        retry_q <= '0;
        run_q   <= '0;
      end else begin
        run_q <= run_q + TIMER_W'(1);
      end
    end
  end

  assign hold_o      = hold_q;
  assign lock_o      = lock_q;
  assign retry_cnt_o = retry_q;
endmodule

// File: rtl/hfs_ov_restart.sv
`timescale 1ns/1ps
module hfs_ov_restart
  import hfs_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               ov_s_i,
  input  logic               timed_i,
  input  logic [TIMER_W-1:0] window_i,
  input  logic               man_reset_i,
  output logic               hold_o,
  output logic               trip_evt_o
);
  logic [TIMER_W-1:0] win_q;
  logic               hold_q, go_q;

  assign trip_evt_o = ov_s_i && !hold_q;
  assign go_q = timed_i ? at_limit(32'(win_q), 32'(window_i)) : man_reset_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      win_q  <= '0;
    end else if (trip_evt_o) begin
      hold_q <= 1'b1;
      win_q  <= '0;
    end else if (hold_q) begin
      if (ov_s_i)                     win_q  <= '0;
      else if (go_q)                  hold_q <= 1'b0;
      else if (tick_i && !(&win_q))   win_q  <= win_q + TIMER_W'(1);
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/hfs_mm_check.sv
`timescale 1ns/1ps
module hfs_mm_check
  import hfs_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic [CNT_W-1:0]  persist_i,
  input  logic [CNT_W-1:0]  release_i,
  output logic              active_o,
  output logic              stop_o,
  output logic              stop_evt_o
);
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             act_q, stop_q, over;

  assign over       = sample_i > limit_i;
  assign stop_evt_o = valid_i && over && !stop_q && next_hits(32'(hi_q), 32'(persist_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      act_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (valid_i) begin
      if (over) begin
        lo_q  <= '0;
        act_q <= 1'b1;
        if (!(&hi_q)) hi_q <= hi_q + CNT_W'(1);
        if (stop_evt_o) stop_q <= 1'b1;
      end else begin
        hi_q <= '0;
        if (act_q) begin
          if (next_hits(32'(lo_q), 32'(release_i))) begin
            act_q  <= 1'b0;
            stop_q <= 1'b0;
            lo_q   <= '0;
          end else begin
            lo_q <= lo_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign active_o = act_q;
  assign stop_o   = stop_q;
endmodule

// File: rtl/hfs_top.sv
`timescale 1ns/1ps
module hfs_top
  import hfs_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CNT_W   = 8,
  parameter int TIMER_W = 16,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oc_flag_i,
  input  logic               ov_flag_i,
  input  logic               tick_i,
  input  logic [DATA_W-1:0]  mm_sample_i,
  input  logic               mm_valid_i,
  input  logic [DATA_W-1:0]  mm_limit_i,
  input  logic [CNT_W-1:0]   mm_persist_i,
  input  logic [CNT_W-1:0]   mm_release_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  input  logic [TIMER_W-1:0] retry_gap_i,
  input  logic [TIMER_W-1:0] retry_clear_i,
  input  logic               ov_timed_i,
  input  logic [TIMER_W-1:0] ov_window_i,
  input  logic               man_reset_i,
  output logic               gate_en_o,
  output logic               derate_o,
  output logic               stop_o,
  output logic               lockout_o,
  output logic [1:0]         fault_layer_o
);
  logic [1:0]         flags_s;
  logic               oc_s, ov_s, quiet;
  logic               oc_hold, oc_lock, oc_trip_evt;
  logic               ov_hold, ov_trip_evt;
  logic               mm_active_w, mm_stop, mm_stop_evt;
  logic               fast_block;
  logic [RETRY_W-1:0] retry_cnt_w;
  layer_e             layer_q;

  hfs_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ov_flag_i, oc_flag_i}), .sync_o(flags_s)
  );
  assign oc_s  = flags_s[0];
  assign ov_s  = flags_s[1];
  assign quiet = !(oc_flag_i || ov_flag_i || oc_s || ov_s);

  hfs_oc_retry #(.TIMER_W(TIMER_W), .RETRY_W(RETRY_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .oc_s_i(oc_s), .quiet_i(quiet),
    .man_reset_i(man_reset_i), .retry_max_i(retry_max_i), .retry_gap_i(retry_gap_i),
    .retry_clear_i(retry_clear_i), .hold_o(oc_hold), .lock_o(oc_lock),
    .trip_evt_o(oc_trip_evt), .retry_cnt_o(retry_cnt_w)
  );

  hfs_ov_restart #(.TIMER_W(TIMER_W)) u_ov (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ov_s_i(ov_s), .timed_i(ov_timed_i),
    .window_i(ov_window_i), .man_reset_i(man_reset_i),
    .hold_o(ov_hold), .trip_evt_o(ov_trip_evt)
  );

  hfs_mm_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mm (
    .clk(clk), .rst_n(rst_n), .sample_i(mm_sample_i), .valid_i(mm_valid_i),
    .limit_i(mm_limit_i), .persist_i(mm_persist_i), .release_i(mm_release_i),
    .active_o(mm_active_w), .stop_o(mm_stop), .stop_evt_o(mm_stop_evt)
  );

  // fault layer record: fast trips overwrite, supervisory only fills an empty slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               layer_q <= LAYER_NONE;
    else if (ov_trip_evt)                     layer_q <= LAYER_OV;
    else if (oc_trip_evt)                     layer_q <= LAYER_OC;
    else if (man_reset_i && quiet)            layer_q <= LAYER_NONE;
    else if (mm_stop_evt && layer_q == LAYER_NONE) layer_q <= LAYER_SUP;
  end

  // raw flags reach the gate without passing the synchronizer
  assign fast_block    = oc_flag_i || ov_flag_i || oc_s || ov_s || oc_hold || ov_hold || oc_lock;
  assign gate_en_o     = !(oc_flag_i || ov_flag_i || oc_hold || ov_hold || oc_lock || mm_stop);
  assign derate_o      = mm_active_w && !fast_block;
  assign stop_o        = mm_stop;
  assign lockout_o     = oc_lock;
  assign fault_layer_o = layer_q;
endmodule

// File: rtl/hfs_chk.sv
`timescale 1ns/1ps
module hfs_chk #(
  parameter int RETRY_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oc_flag_i,
  input logic               ov_flag_i,
  input logic               man_reset_i,
  input logic               gate_en_o,
  input logic               derate_o,
  input logic               stop_o,
  input logic               lockout_o,
  input logic [1:0]         fault_layer_o,
  input logic               mm_active_w,
  input logic [RETRY_W-1:0] retry_cnt_w,
  input logic [RETRY_W-1:0] retry_max_i
);
  // R1
  oc_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag_i |-> !gate_en_o);
  // R5
  ov_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag_i |-> !gate_en_o);
  // R3
  lock_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_o |-> !gate_en_o);
  // R3
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt_w <= retry_max_i);
  // R7
  stop_needs_derate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> mm_active_w);
  // R9
  derate_gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (derate_o && !stop_o) |-> gate_en_o);
  // R11
  lock_clear_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout_o) |-> $past(man_reset_i));
  // R10
  layer_clear_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_layer_o == 2'd0 && $past(fault_layer_o) != 2'd0) |-> $past(man_reset_i));
endmodule

bind hfs_top hfs_chk #(.RETRY_W(RETRY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .oc_flag_i(oc_flag_i), .ov_flag_i(ov_flag_i),
  .man_reset_i(man_reset_i), .gate_en_o(gate_en_o), .derate_o(derate_o),
  .stop_o(stop_o), .lockout_o(lockout_o), .fault_layer_o(fault_layer_o),
  .mm_active_w(mm_active_w), .retry_cnt_w(retry_cnt_w), .retry_max_i(retry_max_i)
);

// File: tb/hfs_top_tb_top.sv
`timescale 1ns/1ps
module hfs_top_tb_top;
  localparam int DATA_W = 10, CNT_W = 8, TIMER_W = 16, RETRY_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oc = 1'b0, ov = 1'b0, tick = 1'b1, mval = 1'b0, mrst = 1'b0, timed = 1'b0;
  logic [DATA_W-1:0]  msamp = '0, mlim = 10'd500;
  logic [CNT_W-1:0]   persist = 8'd3, rel = 8'd4;
  logic [RETRY_W-1:0] rmax = 3'd2;
  logic [TIMER_W-1:0] rgap = 16'd40, rclr = 16'd100, owin = 16'd30;
  logic gate, der, stp, lck;
  logic [1:0] layer;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_hi = 0, m_lo = 0, m_act = 0, m_stop = 0;

  always #5 clk = ~clk;

  hfs_top #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TIMER_W(TIMER_W), .RETRY_W(RETRY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .ov_flag_i(ov), .tick_i(tick),
    .mm_sample_i(msamp), .mm_valid_i(mval), .mm_limit_i(mlim), .mm_persist_i(persist),
    .mm_release_i(rel), .retry_max_i(rmax), .retry_gap_i(rgap), .retry_clear_i(rclr),
    .ov_timed_i(timed), .ov_window_i(owin), .man_reset_i(mrst),
    .gate_en_o(gate), .derate_o(der), .stop_o(stp), .lockout_o(lck), .fault_layer_o(layer)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_oc(); oc = 1'b1; cyc(3); oc = 1'b0; endtask
  task automatic pulse_ov(); ov = 1'b1; cyc(3); ov = 1'b0; endtask
  task automatic man_pulse(); mrst = 1'b1; cyc(1); mrst = 1'b0; endtask

  // bench model of the mismatch rules (R7, R8)
  function automatic void model_step(input int s);
    if (s > int'(mlim)) begin
      m_lo = 0; m_act = 1; m_hi++;
      if (m_hi >= int'(persist)) m_stop = 1;
    end else begin
      m_hi = 0;
      if (m_act == 1) begin
        m_lo++;
        if (m_lo >= int'(rel)) begin m_act = 0; m_stop = 0; m_lo = 0; end
      end
    end
  endfunction

  task automatic mm_send(input int s);
    msamp = DATA_W'(s); mval = 1'b1;
    cyc(1);
    mval = 1'b0;
    model_step(s);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    cyc(3); rst_n = 1'b1; cyc(2);
    // R12 reset state
    chk("R12 gate", gate, 1); chk("R12 derate", der, 0); chk("R12 stop", stp, 0);
    chk("R12 lockout", lck, 0); chk("R12 layer", layer, 0);

    // R1 immediate, R2 retry interval
    oc = 1'b1; #1; chk("R1 gate same cycle", gate, 0);
    cyc(3); oc = 1'b0;
    cyc(17); chk("R2 gate held during interval", gate, 0); chk("R10 layer oc", layer, 1);
    cyc(40); chk("R2 gate auto restored", gate, 1);

    // R3 lockout after retry_max recoveries
    pulse_oc(); cyc(57); chk("R3 second recovery", gate, 1); chk("R3 no lock yet", lck, 0);
    pulse_oc(); cyc(57); chk("R3 lockout", lck, 1); chk("R3 gate off in lock", gate, 0);
    // R11 manual reset ignored with flag active
    oc = 1'b1; cyc(4); man_pulse(); chk("R11 lock kept with flag", lck, 1);
    oc = 1'b0; cyc(5); man_pulse();
    chk("R11 lock cleared", lck, 0); chk("R11 gate back", gate, 1); chk("R10 layer cleared", layer, 0);

    // R4 sparse trips never lock
    for (int k = 0; k < 4; k++) begin
      pulse_oc(); cyc(60);
      chk("R4 sparse no lock", lck, 0); chk("R4 sparse gate", gate, 1);
      cyc(190);
    end
    man_pulse();

    // R5 manual over-voltage restart
    ov = 1'b1; #1; chk("R5 gate same cycle", gate, 0);
    cyc(4); man_pulse(); ov = 1'b0;
    cyc(10); chk("R5 reset during flag ignored", gate, 0); chk("R10 layer ov", layer, 2);
    cyc(40); chk("R5 stays off", gate, 0);
    man_pulse(); chk("R5 manual restart", gate, 1);

    // R6 timed restart
    timed = 1'b1; cyc(2);
    pulse_ov(); cyc(17); chk("R6 off in window", gate, 0);
    cyc(40); chk("R6 timed restart", gate, 1);
    tick = 1'b0; pulse_ov(); cyc(100); chk("R6 no restart without tick", gate, 0);
    tick = 1'b1; cyc(50); chk("R6 restart once ticking", gate, 1);
    timed = 1'b0; man_pulse();

    // R9 fast priority over derate
    mm_send(700); chk("R7 derate on", der, 1); chk("R7 gate on", gate, 1);
    oc = 1'b1; #1; chk("R9 derate masked", der, 0); chk("R9 gate off", gate, 0);
    cyc(3); oc = 1'b0; cyc(60); chk("R9 derate back", der, 1);
    for (int k = 0; k < 3; k++) mm_send(100);
    chk("R8 still derated", der, 1);
    mm_send(100); chk("R8 released", der, 0);
    // R10 supervisory does not overwrite fast code
    for (int k = 0; k < 3; k++) mm_send(800);
    chk("R7 stop", stp, 1); chk("R10 fast code kept", layer, 1);
    for (int k = 0; k < 4; k++) mm_send(0);
    man_pulse(); chk("R10 cleared", layer, 0);

    // R7 / R8 directed
    mm_send(600); mm_send(600); mm_send(500); mm_send(600); mm_send(600);
    chk("R7 broken run no stop", stp, 0);
    mm_send(600); chk("R7 stop after persist", stp, 1); chk("R7 gate off", gate, 0);
    chk("R10 layer sup", layer, 3);
    mm_send(1); mm_send(1); mm_send(1); mm_send(900);
    chk("R8 broken release", stp, 1);
    mm_send(1); mm_send(1); mm_send(1); chk("R8 not yet", stp, 1);
    mm_send(1); chk("R8 stop released", stp, 0); chk("R8 gate back", gate, 1);
    man_pulse();

    // random mismatch samples against the bench model
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) != 0) mm_send(int'($urandom_range(420, 580)));
      else cyc(1);
      chk("R7 random derate", der, m_act); chk("R7 random stop", stp, m_stop);
      chk("R8 random gate", gate, (m_stop == 1) ? 0 : 1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule